// File: doc/BRIEF.md
# Round-Robin Backplane System Controller

This block carries out the system-controller duties on a shared backplane. Masters raise requests on four levels. The block hands out one grant at a time. Priority rotates across the levels, so a level that has just been served goes to the back of the queue and no level can be locked out. A single-level mode limits arbitration to the top level (index 3) alone.

A watchdog timer guards each slave transfer. When a data strobe stays up for a programmed number of cycles without an acknowledge, the block raises bus error. Bus error stays up until the strobe is removed. A local reset request is passed on to the backplane reset line.

The whole function is switched on by a strap pin. No writable register can switch it on. A registered status bit reports the strap state.

Top module: `sysctl_arb`

## Requirements
- R1: After the block grants level k, the next search for a requester starts at level (k+1) mod 4 and proceeds upward with wraparound. The lowest-offset requesting level from that start point wins.
- R2: While `solo_mode` is 1, only a request on level 3 can be granted, and requests on levels 0 to 2 produce no grant.
- R3: The block is idle when no grant is out and no owner holds the bus. If the block is idle, `bus_busy` is 0 and an eligible request is present on a clock edge, the grant appears on `bus_grant` after that edge. At most one grant bit is ever 1.
- R4: A grant is held until `bus_busy` is seen at 1, or until the granted level withdraws its request. Either event drops the grant at the next edge. While `bus_busy` stays 1, no new grant is issued.
- R5: Between two grants, `bus_grant` is all zero for at least one cycle.
- R6: With the controller enabled, `bp_reset` follows `local_rst` with one cycle of latency.
- R7: With timeout setting T>0, `bus_err` rises after the T-th consecutive edge at which `dstrb` is 1 and `dack` is 0.
- R8: An edge with `dack` at 1 clears the timeout count, and counting restarts from zero.
- R9: `bus_err` stays 1 while `dstrb` stays 1. It drops one edge after `dstrb` goes to 0. A timeout setting of 0 keeps `bus_err` at 0.
- R10: When `strap_en` is 0, `bus_grant`, `bp_reset` and `bus_err` are 0 after the next edge. `ctl_on` equals `strap_en` delayed by one edge, and it is 0 during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_en | input | 1 | Strap that enables the controller |
| solo_mode | input | 1 | 1: arbitrate level 3 only |
| bus_req | input | 4 | Request per level |
| bus_busy | input | 1 | Bus held by the current owner |
| local_rst | input | 1 | Local reset request |
| dstrb | input | 1 | Data strobe of the current transfer |
| dack | input | 1 | Slave acknowledge |
| tmo_cycles | input | 16 | Bus-error timeout in cycles, 0 disables |
| bus_grant | output | 4 | One-hot grant per level |
| bp_reset | output | 1 | Backplane reset |
| bus_err | output | 1 | Bus error |
| ctl_on | output | 1 | Status: controller enabled |

## Verification
Every output of this block is registered. Any input change made between edges therefore shows up at the ports after exactly one edge. This applies to a grant, a grant drop, backplane reset, the status bit, and bus error once its count is reached. Bus error is due on the T-th strobed edge with no acknowledge. Inputs are driven on the falling edge. A behavioural model advances on each rising edge and is compared with the ports at the following falling edge. Directed checks sample at those same falling edges and count edges from the stimulus.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  typedef enum logic [1:0] {
    ARB_IDLE  = 2'd0,
    ARB_GRANT = 2'd1,
    ARB_OWNED = 2'd2
  } arb_state_e;
endpackage

// File: rtl/sysctl_rr_pick.sv
module sysctl_rr_pick #(
  parameter int NLVL = 4,
  localparam int PW = $clog2(NLVL)
) (
  input  logic [NLVL-1:0] req,
  input  logic [PW-1:0]   start,
  output logic            found,
  output logic [PW-1:0]   pick
);
  logic [NLVL-1:0] rot;
  logic [PW-1:0]   off;

  for (genvar g = 0; g < NLVL; g++) begin : g_rot
    logic [PW-1:0] idx;
    assign idx    = start + PW'(g);
    assign rot[g] = req[idx];
  end

  always_comb begin
    off   = '0;
    found = 1'b0;
    for (int i = NLVL - 1; i >= 0; i--) begin
      if (rot[i]) begin
        off   = PW'(i);
        found = 1'b1;
      end
    end
    pick = start + off;
  end
endmodule

// File: rtl/sysctl_arb_fsm.sv
module sysctl_arb_fsm
  import sysctl_pkg::*;
#(
  parameter int NLVL = 4,
  localparam int PW = $clog2(NLVL),
  localparam int SOLO_LVL = NLVL - 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            solo,
  input  logic [NLVL-1:0] req,
  input  logic            busy,
  output logic [NLVL-1:0] grant
);
  arb_state_e      st_q, st_d;
  logic [PW-1:0]   ptr_q, ptr_d;
  logic [PW-1:0]   own_q, own_d;
  logic [NLVL-1:0] grant_q, grant_d;
  logic [NLVL-1:0] elig;
  logic            hit;
  logic [PW-1:0]   win;

  assign elig = solo ? (req & (NLVL'(1) << SOLO_LVL)) : req;

  sysctl_rr_pick #(.NLVL(NLVL)) u_pick (
    .req   (elig),
    .start (ptr_q),
    .found (hit),
    .pick  (win)
  );

  always_comb begin
    st_d    = st_q;
    ptr_d   = ptr_q;
    own_d   = own_q;
    grant_d = grant_q;
    if (!en) begin
      st_d    = ARB_IDLE;
      grant_d = '0;
    end else begin
      unique case (st_q)
        ARB_IDLE: begin
          if (!busy && hit) begin
            st_d    = ARB_GRANT;
            own_d   = win;
            ptr_d   = win + PW'(1);
            grant_d = NLVL'(1) << win;
          end
        end
        ARB_GRANT: begin
          if (busy) begin
            st_d    = ARB_OWNED;
            grant_d = '0;
          end else if (!req[own_q]) begin
            st_d    = ARB_IDLE;
            grant_d = '0;
          end
        end
        ARB_OWNED: begin
          if (!busy) st_d = ARB_IDLE;
        end
        default: begin
          st_d    = ARB_IDLE;
          grant_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ARB_IDLE;
      ptr_q   <= '0;
      own_q   <= '0;
      grant_q <= '0;
    end else begin
      st_q    <= st_d;
      ptr_q   <= ptr_d;
      own_q   <= own_d;
      grant_q <= grant_d;
    end
  end

  assign grant = grant_q;

  // R3
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_q));

  // R4
  busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ARB_IDLE && busy) |=> (grant_q == '0));

  // R5
  grant_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_q != '0) |=> (grant_q == '0 || grant_q == $past(grant_q)));

  // R2
  solo_only_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ARB_IDLE && solo && en) |=> (grant_q[NLVL-2:0] == '0));
endmodule

// File: rtl/sysctl_bus_timer.sv
module sysctl_bus_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [TW-1:0] tmo,
  input  logic          dstrb,
  input  logic          dack,
  output logic          err
);
  logic [TW-1:0] cnt_q, cnt_d, cnt_inc;
  logic          err_q, err_d;

  assign cnt_inc = cnt_q + TW'(1);

  always_comb begin
    cnt_d = cnt_q;
    err_d = err_q;
    if (!en || tmo == '0 || !dstrb) begin
      cnt_d = '0;
      err_d = 1'b0;
    end else if (dack) begin
      cnt_d = '0;
    end else if (!err_q) begin
      cnt_d = cnt_inc;
      if (cnt_inc == tmo) err_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      err_q <= err_d;
    end
  end

  assign err = err_q;

  // R9
  err_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && dstrb && en && tmo != '0) |=> err_q);

  // R9
  zero_tmo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo == '0) |=> !err_q);

  // R8
  ack_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dack && !err_q) |=> !err_q);
endmodule

// File: rtl/sysctl_arb.sv
module sysctl_arb #(
  parameter int NLVL = 4,
  parameter int TW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            strap_en,
  input  logic            solo_mode,
  input  logic [NLVL-1:0] bus_req,
  input  logic            bus_busy,
  input  logic            local_rst,
  input  logic            dstrb,
  input  logic            dack,
  input  logic [TW-1:0]   tmo_cycles,
  output logic [NLVL-1:0] bus_grant,
  output logic            bp_reset,
  output logic            bus_err,
  output logic            ctl_on
);
  logic rst_fwd_q, rst_fwd_d;
  logic on_q;

  sysctl_arb_fsm #(.NLVL(NLVL)) u_fsm (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (strap_en),
    .solo  (solo_mode),
    .req   (bus_req),
    .busy  (bus_busy),
    .grant (bus_grant)
  );

  sysctl_bus_timer #(.TW(TW)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (strap_en),
    .tmo   (tmo_cycles),
    .dstrb (dstrb),
    .dack  (dack),
    .err   (bus_err)
  );

  assign rst_fwd_d = strap_en & local_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_fwd_q <= 1'b0;
      on_q      <= 1'b0;
    end else begin
      rst_fwd_q <= rst_fwd_d;
      on_q      <= strap_en;
    end
  end

  assign bp_reset = rst_fwd_q;
  assign ctl_on   = on_q;

  // R6
  rst_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strap_en && local_rst) |=> bp_reset);

  // R10
  strap_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strap_en |=> (bus_grant == '0 && !bp_reset && !bus_err && !ctl_on));
endmodule

// File: tb/sim_sysctl_arb.sv
module sim_sysctl_arb;
  localparam int CLK_NS = 10;
  localparam int NLVL = 4;
  localparam int TW = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic strap_en, solo_mode, bus_busy, local_rst, dstrb, dack;
  logic [NLVL-1:0] bus_req;
  logic [TW-1:0] tmo_cycles;
  logic [NLVL-1:0] bus_grant;
  logic bp_reset, bus_err, ctl_on;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  // reference model state
  int m_state, m_ptr, m_own, m_cnt;
  logic [NLVL-1:0] m_grant;
  logic m_err, m_rst, m_on;

  sysctl_arb #(.NLVL(NLVL), .TW(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .strap_en(strap_en), .solo_mode(solo_mode),
    .bus_req(bus_req), .bus_busy(bus_busy), .local_rst(local_rst),
    .dstrb(dstrb), .dack(dack), .tmo_cycles(tmo_cycles),
    .bus_grant(bus_grant), .bp_reset(bp_reset), .bus_err(bus_err), .ctl_on(ctl_on)
  );

  always #(CLK_NS/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic model_reset();
    m_state = 0; m_ptr = 0; m_own = 0; m_cnt = 0;
    m_grant = '0; m_err = 0; m_rst = 0; m_on = 0;
  endtask

  task automatic model_update();
    bit found;
    int lvl;
    if (!rst_n) begin
      model_reset();
      return;
    end
    m_on  = strap_en;
    m_rst = strap_en & local_rst;
    if (!strap_en) begin
      m_state = 0; m_grant = '0;
    end else if (m_state == 0) begin
      if (!bus_busy) begin
        found = 0;
        for (int i = 0; i < NLVL; i++) begin
          lvl = (m_ptr + i) % NLVL;
          if (!found && bus_req[lvl] && (!solo_mode || lvl == NLVL - 1)) begin
            found = 1; m_own = lvl; m_ptr = (lvl + 1) % NLVL;
            m_grant = NLVL'(1) << lvl; m_state = 1;
          end
        end
      end
    end else if (m_state == 1) begin
      if (bus_busy) begin
        m_grant = '0; m_state = 2;
      end else if (!bus_req[m_own]) begin
        m_grant = '0; m_state = 0;
      end
    end else begin
      if (!bus_busy) m_state = 0;
    end
    if (!strap_en || tmo_cycles == 0 || !dstrb) begin
      m_cnt = 0; m_err = 0;
    end else if (dack) begin
      m_cnt = 0;
    end else if (!m_err) begin
      m_cnt++;
      if (m_cnt == int'(tmo_cycles)) m_err = 1;
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_update();
    @(negedge clk);
    check(bus_grant == m_grant, "R3 grant vs model", bus_grant, m_grant);
    check(bus_err == m_err, "R7 bus_err vs model", bus_err, m_err);
    check(bp_reset == m_rst, "R6 bp_reset vs model", bp_reset, m_rst);
    check(ctl_on == m_on, "R10 ctl_on vs model", ctl_on, m_on);
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
      summary();
    end
  end

  initial begin
    model_reset();
    rst_n = 0; strap_en = 1; solo_mode = 0; bus_req = '0; bus_busy = 0;
    local_rst = 0; dstrb = 0; dack = 0; tmo_cycles = '0;
    steps(3);
    check(bus_grant == 0 && !bus_err && !bp_reset && !ctl_on, "R10 reset state",
          {bus_grant, bus_err, bp_reset, ctl_on}, 0);
    rst_n = 1;
    step();
    // R3: single request granted one edge later
    bus_req = 4'b0010; step();
    check(bus_grant == 4'b0010, "R3 first grant", bus_grant, 4'b0010);
    // R4: busy drops the grant, none while busy
    bus_busy = 1; step();
    check(bus_grant == 0, "R4 grant drop on busy", bus_grant, 0);
    step();
    check(bus_grant == 0, "R4 no grant while busy", bus_grant, 0);
    bus_busy = 0; step();
    check(bus_grant == 0, "R5 idle gap", bus_grant, 0);
    step();
    check(bus_grant == 4'b0010, "R1 regrant lone requester", bus_grant, 4'b0010);
    // R1: rotation with all levels requesting (pointer now 2)
    bus_busy = 1; step(); bus_busy = 0; bus_req = 4'b1111; step(); step();
    check(bus_grant == 4'b0100, "R1 rotate to 2", bus_grant, 4'b0100);
    bus_busy = 1; step(); bus_busy = 0; step(); step();
    check(bus_grant == 4'b1000, "R1 rotate to 3", bus_grant, 4'b1000);
    bus_busy = 1; step(); bus_busy = 0; step(); step();
    check(bus_grant == 4'b0001, "R1 wrap to 0", bus_grant, 4'b0001);
    bus_busy = 1; step(); bus_busy = 0; bus_req = 0; step(); step();
    // R4: withdrawal (pointer 1, only level 0 requests)
    bus_req = 4'b0001; step();
    check(bus_grant == 4'b0001, "R1 wrap search to 0", bus_grant, 4'b0001);
    bus_req = 0; step();
    check(bus_grant == 0, "R4 withdraw drops grant", bus_grant, 0);
    // R2: solo mode
    solo_mode = 1; bus_req = 4'b0111; steps(2);
    check(bus_grant == 0, "R2 low levels ignored", bus_grant, 0);
    bus_req = 4'b1111; step();
    check(bus_grant == 4'b1000, "R2 level 3 served", bus_grant, 4'b1000);
    bus_busy = 1; step(); bus_busy = 0; bus_req = 0; solo_mode = 0; step();
    // R4: foreign busy blocks grant from idle
    bus_busy = 1; bus_req = 4'b0001; step();
    check(bus_grant == 0, "R4 busy blocks idle grant", bus_grant, 0);
    bus_busy = 0; bus_req = 0; steps(2);
    // R6
    local_rst = 1; step();
    check(bp_reset == 1, "R6 reset forwarded", bp_reset, 1);
    local_rst = 0; step();
    check(bp_reset == 0, "R6 reset released", bp_reset, 0);
    // R7 / R9
    tmo_cycles = 3; dstrb = 1; steps(2);
    check(bus_err == 0, "R7 no error before T", bus_err, 0);
    step();
    check(bus_err == 1, "R7 error at T", bus_err, 1);
    steps(2);
    check(bus_err == 1, "R9 error held", bus_err, 1);
    dstrb = 0; step();
    check(bus_err == 0, "R9 error cleared", bus_err, 0);
    // R8
    dstrb = 1; steps(2); dack = 1; step(); dack = 0; steps(2);
    check(bus_err == 0, "R8 ack restarts count", bus_err, 0);
    step();
    check(bus_err == 1, "R8 error after restart", bus_err, 1);
    dstrb = 0; step();
    // R9: zero timeout
    tmo_cycles = 0; dstrb = 1; steps(10);
    check(bus_err == 0, "R9 zero timeout disables", bus_err, 0);
    dstrb = 0; step();
    // R10: strap off
    strap_en = 0; bus_req = 4'b1111; dstrb = 1; tmo_cycles = 2; local_rst = 1;
    step();
    check(bus_grant == 0 && !bp_reset && !bus_err, "R10 outputs idle",
          {bus_grant, bp_reset, bus_err}, 0);
    check(ctl_on == 0, "R10 status off", ctl_on, 0);
    steps(4);
    check(bus_grant == 0 && !bus_err, "R10 stays idle", {bus_grant, bus_err}, 0);
    strap_en = 1; local_rst = 0; dstrb = 0; bus_req = 0; step();
    check(ctl_on == 1, "R10 status on", ctl_on, 1);
    // random phase compared with model every cycle
    for (int k = 0; k < 4000; k++) begin
      if (k % 500 == 0) tmo_cycles = TW'($urandom_range(0, 5));
      bus_req   = NLVL'($urandom);
      if ($urandom_range(0, 3) == 0) bus_busy = ~bus_busy;
      if (k % 300 == 0) solo_mode = ($urandom_range(0, 2) == 0);
      strap_en  = ($urandom_range(0, 19) != 0);
      local_rst = ($urandom_range(0, 9) == 0);
      if ($urandom_range(0, 7) == 0) dstrb = ~dstrb;
      dack      = ($urandom_range(0, 11) == 0);
      step();
    end
    done = 1;
    summary();
  end
endmodule